// File: doc/BRIEF.md
# Near-Call Return Address Stack

This block predicts the target of near return instructions. It watches a stream of retired instruction events. Each event carries a type code, a call displacement, the instruction address and the instruction length. When a near call with a nonzero displacement retires, the block records the address that follows the call, which is the call address plus its length. When a near return is presented, the block drives the most recent recorded address out as the predicted target and raises a valid flag. It drops that entry in the same clock edge.

Storage is a fixed ring of entries addressed by a wrapping top pointer. A call that arrives when the ring is full overwrites the oldest entry. A return that arrives when the ring is empty gets no prediction and leaves the pointer where it is. Far calls, far returns and interrupt returns never touch the ring and never get a prediction. A flush pulse empties the ring in one cycle.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset the stack is empty, so a near return (kind code 3) gives pred_valid_o = 0.
- R2: A valid near call (kind code 1) with a nonzero displacement records ev_addr_i + ev_len_i, truncated to the address width. The next near return predicts that value with pred_valid_o = 1 in the same cycle the return is presented.
- R3: Predictions come out in last-in, first-out order across nested calls. Each near return that is predicted removes exactly one entry.
- R4: A near call whose displacement is zero leaves the stack contents and pointer unchanged.
- R5: Far call (code 2), far return (code 4), interrupt return (code 5) and other (code 0) leave the stack unchanged. They always see pred_valid_o = 0.
- R6: A near return presented when the stack is empty gives pred_valid_o = 0 and does not move the pointer.
- R7: When the stack holds DEPTH entries, a further push overwrites the oldest entry. The DEPTH pops that follow return the newest DEPTH addresses, and the pop after them is not valid.
- R8: flush_i empties the stack by the next cycle. An event in the same cycle as a flush is discarded and receives no prediction.
- R9: pred_addr_o is zero whenever pred_valid_o is low.
- R10: An event with ev_valid_i low changes nothing and gets no prediction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ev_valid_i | input | 1 | A retired instruction event is present |
| ev_kind_i | input | 3 | Type code: 0 other, 1 near call, 2 far call, 3 near return, 4 far return, 5 interrupt return |
| ev_disp_i | input | DW | Call displacement |
| ev_addr_i | input | AW | Instruction address |
| ev_len_i | input | LW | Instruction length in bytes |
| flush_i | input | 1 | Empty the stack |
| pred_valid_o | output | 1 | A prediction is supplied for the presented near return |
| pred_addr_o | output | AW | Predicted return address |

## Verification
A flush and a push or pop can fall in the same cycle. A push can also arrive while the ring is full. The bench provokes the first case in directed steps: it presents a near call or a populated near return together with flush_i. It then judges that the return got no prediction and that a later return on the emptied stack is invalid. A random run also raises a flush at a low rate while calls and returns keep flowing. Every return is compared against a shifting software list. That list drops its oldest element when full, so wrap-around overwrite is judged independently of the ring pointer.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [2:0] {
    EV_OTHER    = 3'd0,
    EV_NEAR_CALL = 3'd1,
    EV_FAR_CALL  = 3'd2,
    EV_NEAR_RET  = 3'd3,
    EV_FAR_RET   = 3'd4,
    EV_INT_RET   = 3'd5
  } ev_kind_e;
endpackage

// File: rtl/ras_ptr.sv
module ras_ptr #(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic [PW-1:0] wr_idx_o,
  output logic [PW-1:0] rd_idx_o,
  output logic          empty_o
);
  logic [PW-1:0] top_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] top_inc, top_dec;

  assign top_inc  = (top_q == PW'(DEPTH - 1)) ? '0 : top_q + 1'b1;
  assign top_dec  = (top_q == '0) ? PW'(DEPTH - 1) : top_q - 1'b1;
  assign wr_idx_o = top_q;
  assign rd_idx_o = top_dec;
  assign empty_o  = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      top_q <= '0;
      cnt_q <= '0;
    end else if (push_i) begin
      top_q <= top_inc;
      if (cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      top_q <= top_dec;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

  // R3
  pop_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !flush_i && !empty_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R6
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !flush_i && empty_o) |=> $stable(top_q));
endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int DEPTH = 16,
  parameter int AW = 32,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [PW-1:0] wr_idx_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic [PW-1:0] rd_idx_i,
  output logic [AW-1:0] rd_data_o
);
  logic [AW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (we_i && wr_idx_i == PW'(g)) mem_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 4,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ev_valid_i,
  input  logic [2:0]    ev_kind_i,
  input  logic [DW-1:0] ev_disp_i,
  input  logic [AW-1:0] ev_addr_i,
  input  logic [LW-1:0] ev_len_i,
  input  logic          flush_i,
  output logic          pred_valid_o,
  output logic [AW-1:0] pred_addr_o
);
  ev_kind_e      kind;
  logic          push, pop_req, empty;
  logic [PW-1:0] wr_idx, rd_idx;
  logic [AW-1:0] next_pc, rd_data;

  assign kind    = ev_kind_e'(ev_kind_i);
  assign next_pc = ev_addr_i + AW'(ev_len_i);
  assign push    = ev_valid_i && !flush_i && kind == EV_NEAR_CALL && ev_disp_i != '0;
  assign pop_req = ev_valid_i && !flush_i && kind == EV_NEAR_RET;

  ras_ptr #(.DEPTH(DEPTH)) i_ptr (
    .clk_i, .rst_ni,
    .push_i(push), .pop_i(pop_req), .flush_i,
    .wr_idx_o(wr_idx), .rd_idx_o(rd_idx), .empty_o(empty)
  );

  ras_store #(.DEPTH(DEPTH), .AW(AW)) i_store (
    .clk_i, .rst_ni,
    .we_i(push), .wr_idx_i(wr_idx), .wr_data_i(next_pc),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  assign pred_valid_o = pop_req && !empty;
  assign pred_addr_o  = pred_valid_o ? rd_data : '0;

  // R5
  only_near_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> (ev_valid_i && ev_kind_i == 3'd3 && !flush_i));

  // R5
  far_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && !flush_i && (ev_kind_i == 3'd2 || ev_kind_i == 3'd4 || ev_kind_i == 3'd5))
      |=> ($stable(wr_idx) && $stable(empty)));

  // R4
  zero_disp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && !flush_i && ev_kind_i == 3'd1 && ev_disp_i == '0) |=> $stable(wr_idx));

  // R8
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty);

  // R9
  addr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_valid_o |-> (pred_addr_o == '0));

  // R2
  push_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |=> !empty);
endmodule

// File: tb/test_ret_addr_stack.sv
`timescale 1ns/1ps
module test_ret_addr_stack;
  localparam int DEPTH = 16;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ev_valid_i = 1'b0;
  logic [2:0]    ev_kind_i = 3'd0;
  logic [DW-1:0] ev_disp_i = '0;
  logic [AW-1:0] ev_addr_i = '0;
  logic [LW-1:0] ev_len_i = '0;
  logic          flush_i = 1'b0;
  logic          pred_valid_o;
  logic [AW-1:0] pred_addr_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [AW-1:0] model [DEPTH];
  int mcnt = 0;

  always #10 clk = ~clk;

  ret_addr_stack #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .LW(LW)) i_ret_addr_stack (
    .clk_i(clk), .rst_ni,
    .ev_valid_i, .ev_kind_i, .ev_disp_i, .ev_addr_i, .ev_len_i, .flush_i,
    .pred_valid_o, .pred_addr_o
  );

  task automatic step(input bit v, input logic [2:0] k, input logic [DW-1:0] d,
                      input logic [AW-1:0] a, input logic [LW-1:0] l, input bit f,
                      input string req);
    bit exp_v;
    logic [AW-1:0] exp_a;
    @(negedge clk);
    ev_valid_i = v; ev_kind_i = k; ev_disp_i = d; ev_addr_i = a; ev_len_i = l; flush_i = f;
    #1;
    exp_v = 1'b0;
    exp_a = '0;
    if (f) begin
      mcnt = 0;
    end else if (v && k == 3'd3) begin
      if (mcnt > 0) begin
        exp_v = 1'b1;
        exp_a = model[mcnt-1];
        mcnt--;
      end
    end else if (v && k == 3'd1 && d != '0) begin
      if (mcnt == DEPTH) begin
        for (int i = 0; i < DEPTH - 1; i++) model[i] = model[i+1];
        model[DEPTH-1] = a + AW'(l);
      end else begin
        model[mcnt] = a + AW'(l);
        mcnt++;
      end
    end
    checks++;
    if (pred_valid_o !== exp_v || pred_addr_o !== exp_a) begin
      fails++;
      $display("FAIL %s: valid=%0b addr=%h expected valid=%0b addr=%h",
               req, pred_valid_o, pred_addr_o, exp_v, exp_a);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    ev_valid_i = 1'b0; flush_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;
    // R1: empty after reset
    step(1, 3'd3, 0, 32'h100, 2, 0, "R1");
    // R2: single call/return
    step(1, 3'd1, 32'h40, 32'h1000, 5, 0, "R2");
    step(1, 3'd3, 0, 32'h2000, 1, 0, "R2");
    // R2: address wraps at width
    step(1, 3'd1, 32'h1, 32'hFFFF_FFFE, 5, 0, "R2");
    step(1, 3'd3, 0, 32'h0, 1, 0, "R2");
    // R3: nesting
    for (int i = 0; i < 5; i++) step(1, 3'd1, 32'h8, 32'h3000 + 32'(i * 64), 4'(i + 2), 0, "R3");
    for (int i = 0; i < 5; i++) step(1, 3'd3, 0, 32'h0, 1, 0, "R3");
    // R4: zero displacement
    step(1, 3'd1, 32'h10, 32'h500, 3, 0, "R4");
    step(1, 3'd1, 32'h0, 32'h900, 5, 0, "R4");
    step(1, 3'd3, 0, 0, 1, 0, "R4");
    step(1, 3'd3, 0, 0, 1, 0, "R4");
    // R5: far transfers and other
    step(1, 3'd1, 32'h10, 32'h700, 2, 0, "R5");
    for (int k = 0; k < 8; k++)
      if (k != 1 && k != 3) step(1, 3'(k), 32'h20, 32'hA00, 7, 0, "R5");
    step(1, 3'd3, 0, 0, 1, 0, "R5");
    // R6: empty return then push still works
    step(1, 3'd3, 0, 0, 1, 0, "R6");
    step(1, 3'd3, 0, 0, 1, 0, "R6");
    step(1, 3'd1, 32'h4, 32'hB00, 6, 0, "R6");
    step(1, 3'd3, 0, 0, 1, 0, "R6");
    step(1, 3'd3, 0, 0, 1, 0, "R6");
    // R7: overflow
    for (int i = 0; i < DEPTH + 3; i++) step(1, 3'd1, 32'h2, 32'h4000 + 32'(i * 16), 3, 0, "R7");
    for (int i = 0; i < DEPTH + 1; i++) step(1, 3'd3, 0, 0, 1, 0, "R7");
    // R8: flush, and flush with same-cycle events
    step(1, 3'd1, 32'h2, 32'h5000, 3, 0, "R8");
    step(1, 3'd1, 32'h2, 32'h5100, 3, 0, "R8");
    step(1, 3'd3, 0, 0, 1, 1, "R8");
    step(1, 3'd3, 0, 0, 1, 0, "R8");
    step(1, 3'd1, 32'h2, 32'h5200, 3, 1, "R8");
    step(1, 3'd3, 0, 0, 1, 0, "R8");
    // R10: valid low
    step(1, 3'd1, 32'h2, 32'h6000, 3, 0, "R10");
    step(0, 3'd1, 32'h2, 32'h6100, 3, 0, "R10");
    step(0, 3'd3, 0, 0, 1, 0, "R10");
    step(1, 3'd3, 0, 0, 1, 0, "R10");
    // R9 and mixed: random sequences
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      logic [2:0] k;
      logic [DW-1:0] d;
      if (r < 40) k = 3'd1;
      else if (r < 78) k = 3'd3;
      else k = 3'($urandom_range(0, 7));
      d = ($urandom_range(0, 3) == 0) ? '0 : DW'($urandom);
      step($urandom_range(0, 15) != 0, k, d, AW'($urandom), LW'($urandom),
           $urandom_range(0, 63) == 0, "R9");
    end
    idle();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule